// File: doc/BRIEF.md
# Memory Operand Address Generator

This block forms the effective address of a load or store operand for a 32-bit processor core. The decoder hands it an operand-mode code, the 12-bit short offset taken from the first instruction word, a scale code, and the contents of a base register and an index register. The block either produces the address directly or first requests the second instruction word, which carries a full 32-bit displacement. Once it has that word, it completes the sum.

Single-word forms finish one cycle after they are accepted. Two-word forms raise a word request and hold until the fetch side returns the displacement with a valid strobe. The address is then presented one cycle later. Invalid combinations raise a one-cycle invalid-operand pulse instead of an address. The block does not read the register file, does not fetch instructions and does not access memory.

Top module: `mem_agen`

## Requirements
- R1: Mode code 0 (short absolute) yields an address equal to the 12-bit offset zero-extended to 32 bits, as a single-word form.
- R2: Mode code 1 (long absolute) yields an address equal to the 32-bit displacement carried by the second word.
- R3: Mode code 2 (base plus short offset) yields the base register value plus the zero-extended 12-bit offset, as a single-word form.
- R4: Mode code 3 (base plus displacement) yields the base register value plus the displacement from the second word.
- R5: Mode code 4 yields base + (index shifted left by the scale code) + displacement. Mode code 5 yields base + shifted index; it still fetches a second word, but that word's value has no effect on the address.
- R6: In modes 4 and 5, scale codes 0 to 4 shift the index left by 0 to 4 bits. Scale codes 5 to 7 in those modes, and mode codes 6 and 7 in any case, produce a one-cycle `bad_op` pulse one cycle after acceptance, with no `ea_valid` and no `word_req`. The scale code is ignored in modes 0 to 3.
- R7: All sums wrap modulo 2^32 and report no overflow.
- R8: A legal single-word form raises `ea_valid` for exactly one cycle, in the cycle after it is accepted, and never raises `word_req`.
- R9: A two-word form raises `word_req` starting in the cycle after acceptance. `word_req` stays high, and `in_ready` stays low, until a cycle in which `word_valid` is high. `ea_valid` is raised in the following cycle and `word_req` falls at the same time. `word_data` is ignored while `word_valid` is low.
- R10: A synchronous active-high reset returns the block to idle: `in_ready` is 1, and `word_req`, `ea_valid` and `bad_op` are 0, including when the reset interrupts a wait for the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand description presented |
| in_ready | output | 1 | Block idle and able to accept |
| in_mode | input | 3 | Operand-mode code |
| in_off | input | 12 | Short offset from the first word |
| in_scale | input | 3 | Index scale code |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| word_req | output | 1 | Request for the second instruction word |
| word_valid | input | 1 | Second word present on word_data |
| word_data | input | 32 | Displacement from the second word |
| ea_valid | output | 1 | Effective address valid (one-cycle pulse) |
| ea | output | 32 | Effective address |
| bad_op | output | 1 | Invalid-operand pulse |

## Verification
The bench sweeps every mode code against every scale code, using all-ones, all-zero and pseudo-random operands. This exposes a design that shifts by the wrong amount, sign-extends the short offset, or adds the second word in mode 5. The all-ones operands force the sums to wrap. A design that saturates, or that drops the carry between the two additions, returns a wrong address for them. Two-word forms are held waiting for zero to two extra cycles, with changing data on `word_data` while `word_valid` is low. A sequencer that captures early or lets `word_req` fall too soon is caught this way. A reset issued during a wait checks that no stale request or address survives it.

// File: rtl/agen_pkg.sv
package agen_pkg;

   typedef enum logic [2:0] {
      AM_ABS_OFF      = 3'd0,
      AM_ABS_DISP     = 3'd1,
      AM_REG_OFF      = 3'd2,
      AM_REG_DISP     = 3'd3,
      AM_REG_IDX_DISP = 3'd4,
      AM_REG_IDX      = 3'd5,
      AM_RSV6         = 3'd6,
      AM_RSV7         = 3'd7
   } am_e;

   typedef struct packed {
      logic use_base;
      logic use_off;
      logic use_disp;
      logic use_idx;
      logic two_word;
      logic illegal;
   } am_ctl_t;

   typedef enum logic {
      AG_IDLE = 1'b0,
      AG_WAIT = 1'b1
   } ag_st_e;

endpackage

// File: rtl/agen_decode.sv
module agen_decode
   import agen_pkg::*;
#(
   parameter int SCW       = 3,
   parameter int MAX_SHIFT = 4
) (
   input  logic [2:0]     mode,
   input  logic [SCW-1:0] scale,
   output am_ctl_t        ctl
);

   initial begin : p_param_chk
      assert (MAX_SHIFT < (1 << SCW)) else $error("MAX_SHIFT does not fit in scale code");
   end

   am_ctl_t base_ctl;

   always_comb begin
      base_ctl = '0;
      unique case (am_e'(mode))
         AM_ABS_OFF:      base_ctl.use_off = 1'b1;
         AM_ABS_DISP:     begin base_ctl.use_disp = 1'b1; base_ctl.two_word = 1'b1; end
         AM_REG_OFF:      begin base_ctl.use_base = 1'b1; base_ctl.use_off = 1'b1; end
         AM_REG_DISP:     begin base_ctl.use_base = 1'b1; base_ctl.use_disp = 1'b1;
                                base_ctl.two_word = 1'b1; end
         AM_REG_IDX_DISP: begin base_ctl.use_base = 1'b1; base_ctl.use_idx = 1'b1;
                                base_ctl.use_disp = 1'b1; base_ctl.two_word = 1'b1; end
         AM_REG_IDX:      begin base_ctl.use_base = 1'b1; base_ctl.use_idx = 1'b1;
                                base_ctl.two_word = 1'b1; end
         default:         base_ctl.illegal = 1'b1;
      endcase
   end

   always_comb begin
      ctl = base_ctl;
      if (base_ctl.use_idx && (scale > SCW'(MAX_SHIFT))) begin
         ctl.illegal  = 1'b1;
      end
      if (ctl.illegal) begin
         ctl.two_word = 1'b0;
      end
   end

endmodule

// File: rtl/agen_scaler.sv
module agen_scaler #(
   parameter int AW        = 32,
   parameter int SCW       = 3,
   parameter int MAX_SHIFT = 4
) (
   input  logic [AW-1:0]  idx,
   input  logic [SCW-1:0] shamt,
   output logic [AW-1:0]  scaled
);

   localparam int NCAND = MAX_SHIFT + 1;

   logic [AW-1:0] cand [NCAND];

   for (genvar k = 0; k < NCAND; k++) begin : g_cand
      assign cand[k] = idx << k;
   end

   always_comb begin
      scaled = '0;
      for (int k = 0; k < NCAND; k++) begin
         if (shamt == SCW'(k)) scaled = cand[k];
      end
   end

endmodule

// File: rtl/agen_adder.sv
module agen_adder #(
   parameter int AW        = 32,
   parameter bit CARRY_SAVE = 1'b1
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic [AW-1:0] c,
   output logic [AW-1:0] sum
);

   if (CARRY_SAVE) begin : g_csa
      logic [AW-1:0] s_vec;
      logic [AW-1:0] c_vec;
      assign s_vec = a ^ b ^ c;
      assign c_vec = ((a & b) | (a & c) | (b & c)) << 1;
      assign sum   = s_vec + c_vec;
   end else begin : g_chain
      logic [AW-1:0] part;
      assign part = a + b;
      assign sum  = part + c;
   end

endmodule

// File: rtl/mem_agen.sv
module mem_agen
   import agen_pkg::*;
#(
   parameter int AW         = 32,
   parameter int OFFW       = 12,
   parameter int SCW        = 3,
   parameter int MAX_SHIFT  = 4,
   parameter bit CARRY_SAVE = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [2:0]     in_mode,
   input  logic [OFFW-1:0] in_off,
   input  logic [SCW-1:0] in_scale,
   input  logic [AW-1:0]  in_base,
   input  logic [AW-1:0]  in_index,
   output logic           word_req,
   input  logic           word_valid,
   input  logic [AW-1:0]  word_data,
   output logic           ea_valid,
   output logic [AW-1:0]  ea,
   output logic           bad_op
);

   localparam int ZPAD = AW - OFFW;

   initial begin : p_param_chk
      assert (OFFW < AW) else $error("offset field must be narrower than address");
      assert (MAX_SHIFT < AW) else $error("shift range exceeds address width");
   end

   ag_st_e         st;
   am_ctl_t        in_ctl, r_ctl, cur_ctl;
   logic [AW-1:0]  r_base, r_idx, cur_base, cur_idx;
   logic [OFFW-1:0] r_off, cur_off;
   logic [SCW-1:0] r_scale, cur_scale;
   logic [AW-1:0]  scaled, t_a, t_b, t_c, total;
   logic           accept, wait_sel, word_hs;

   assign in_ready = (st == AG_IDLE);
   assign word_req = (st == AG_WAIT);
   assign accept   = in_valid && in_ready;
   assign wait_sel = (st == AG_WAIT);
   assign word_hs  = wait_sel && word_valid;

   agen_decode #(.SCW(SCW), .MAX_SHIFT(MAX_SHIFT)) dec_i (
      .mode  (in_mode),
      .scale (in_scale),
      .ctl   (in_ctl)
   );

   assign cur_ctl   = wait_sel ? r_ctl   : in_ctl;
   assign cur_base  = wait_sel ? r_base  : in_base;
   assign cur_idx   = wait_sel ? r_idx   : in_index;
   assign cur_off   = wait_sel ? r_off   : in_off;
   assign cur_scale = wait_sel ? r_scale : in_scale;

   agen_scaler #(.AW(AW), .SCW(SCW), .MAX_SHIFT(MAX_SHIFT)) scl_i (
      .idx    (cur_idx),
      .shamt  (cur_scale),
      .scaled (scaled)
   );

   assign t_a = cur_ctl.use_base ? cur_base : '0;
   assign t_b = cur_ctl.use_idx  ? scaled   : '0;
   assign t_c = cur_ctl.use_off  ? {{ZPAD{1'b0}}, cur_off} :
                cur_ctl.use_disp ? word_data : '0;

   agen_adder #(.AW(AW), .CARRY_SAVE(CARRY_SAVE)) add_i (
      .a   (t_a),
      .b   (t_b),
      .c   (t_c),
      .sum (total)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= AG_IDLE;
         ea_valid <= 1'b0;
         bad_op   <= 1'b0;
         ea       <= '0;
         r_ctl    <= '0;
         r_base   <= '0;
         r_idx    <= '0;
         r_off    <= '0;
         r_scale  <= '0;
      end else begin
         ea_valid <= 1'b0;
         bad_op   <= 1'b0;
         if (accept) begin
            if (in_ctl.illegal) begin
               bad_op <= 1'b1;
            end else if (!in_ctl.two_word) begin
               ea       <= total;
               ea_valid <= 1'b1;
            end else begin
               st      <= AG_WAIT;
               r_ctl   <= in_ctl;
               r_base  <= in_base;
               r_idx   <= in_index;
               r_off   <= in_off;
               r_scale <= in_scale;
            end
         end else if (word_hs) begin
            ea       <= total;
            ea_valid <= 1'b1;
            st       <= AG_IDLE;
         end
      end
   end

   // R8
   one_word_timing_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && !in_ctl.illegal && !in_ctl.two_word) |=> (ea_valid && !word_req));

   // R9
   two_word_req_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && in_ctl.two_word) |=> (word_req && !ea_valid));

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (word_req && !word_valid) |=> (word_req && !in_ready));

   // R9
   word_done_chk: assert property (@(posedge clk) disable iff (rst)
      (word_req && word_valid) |=> (ea_valid && !word_req));

   // R6
   bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
      bad_op |-> (!ea_valid && !word_req));

   // R6
   bad_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && in_ctl.illegal) |=> bad_op);

endmodule

// File: tb/mem_agen_tb.sv
module mem_agen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [2:0]  in_mode = '0;
   logic [11:0] in_off = '0;
   logic [2:0]  in_scale = '0;
   logic [31:0] in_base = '0;
   logic [31:0] in_index = '0;
   logic        word_req;
   logic        word_valid = 1'b0;
   logic [31:0] word_data = '0;
   logic        ea_valid;
   logic [31:0] ea;
   logic        bad_op;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_agen dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_mode(in_mode), .in_off(in_off), .in_scale(in_scale),
      .in_base(in_base), .in_index(in_index), .word_req(word_req),
      .word_valid(word_valid), .word_data(word_data),
      .ea_valid(ea_valid), .ea(ea), .bad_op(bad_op)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   function automatic bit is_bad(input int m, input int s);
      if (m >= 6) return 1'b1;
      if ((m == 4 || m == 5) && s > 4) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_ea(input int m, input int s, input logic [11:0] o,
                                          input logic [31:0] b, input logic [31:0] x,
                                          input logic [31:0] d);
      case (m)
         0: return {20'd0, o};
         1: return d;
         2: return b + {20'd0, o};
         3: return b + d;
         4: return b + (x << s) + d;
         default: return b + (x << s);
      endcase
   endfunction

   function automatic string tag(input int m, input bit wrap);
      if (wrap) return "R7";
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic run_op(input int m, input int s, input logic [11:0] o,
                         input logic [31:0] b, input logic [31:0] x,
                         input logic [31:0] d, input int hold, input bit wrap);
      bit bad;
      bit two;
      bad = is_bad(m, s);
      two = !bad && (m == 1 || m == 3 || m == 4 || m == 5);
      @(negedge clk);
      chk("R9 ready before accept", 32'(in_ready), 32'd1);
      in_mode = 3'(m); in_scale = 3'(s); in_off = o;
      in_base = b; in_index = x; in_valid = 1'b1;
      word_data = ~d;
      @(negedge clk);
      in_valid = 1'b0;
      in_base = next_rand(); in_index = next_rand();
      if (bad) begin
         chk("R6 bad_op", 32'(bad_op), 32'd1);
         chk("R6 no ea_valid", 32'(ea_valid), 32'd0);
         chk("R6 no word_req", 32'(word_req), 32'd0);
      end else if (!two) begin
         chk("R8 ea_valid", 32'(ea_valid), 32'd1);
         chk("R8 no word_req", 32'(word_req), 32'd0);
         chk(tag(m, wrap), ea, exp_ea(m, s, o, b, x, d));
      end else begin
         chk("R9 word_req raised", 32'(word_req), 32'd1);
         chk("R9 no early ea_valid", 32'(ea_valid), 32'd0);
         for (int w = 0; w < hold; w++) begin
            word_data = next_rand();
            @(negedge clk);
            chk("R9 word_req held", 32'(word_req), 32'd1);
            chk("R9 not ready", 32'(in_ready), 32'd0);
         end
         word_data = d; word_valid = 1'b1;
         @(negedge clk);
         word_valid = 1'b0; word_data = next_rand();
         chk("R9 ea_valid after word", 32'(ea_valid), 32'd1);
         chk("R9 word_req dropped", 32'(word_req), 32'd0);
         chk(tag(m, wrap), ea, exp_ea(m, s, o, b, x, d));
      end
      @(negedge clk);
      chk("R8 ea_valid one cycle", 32'(ea_valid), 32'd0);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > WD_LIMIT) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R10 ready after reset", 32'(in_ready), 32'd1);
      chk("R10 word_req after reset", 32'(word_req), 32'd0);
      chk("R10 ea_valid after reset", 32'(ea_valid), 32'd0);
      chk("R10 bad_op after reset", 32'(bad_op), 32'd0);

      for (int m = 0; m < 8; m++) begin
         for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 6; p++) begin
               logic [31:0] b, x, d;
               logic [11:0] o;
               if (p == 0) begin
                  b = '1; x = '1; d = '1; o = '1;
               end else if (p == 1) begin
                  b = '0; x = '0; d = '0; o = '0;
               end else begin
                  b = next_rand(); x = next_rand(); d = next_rand();
                  o = 12'(next_rand());
               end
               run_op(m, s, o, b, x, d, p % 3, p == 0);
            end
         end
      end

      // R10: reset while waiting for the second word
      @(negedge clk);
      in_mode = 3'd3; in_base = 32'h10; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 wait entered", 32'(word_req), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R10 word_req cleared", 32'(word_req), 32'd0);
      chk("R10 ready restored", 32'(in_ready), 32'd1);
      chk("R10 no ea_valid", 32'(ea_valid), 32'd0);
      word_valid = 1'b1; word_data = 32'h55;
      @(negedge clk);
      word_valid = 1'b0;
      chk("R10 stale word ignored", 32'(ea_valid), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule